// File: doc/BRIEF.md
# Host FIFO and Mailbox Window

This block is the board-side end of an eight-address host I/O window. The host moves bulk data through two FIFOs: an outbound one that it fills and the local processor drains, and an inbound one that runs the other way. Each host data transfer is either a full 16-bit word or a single byte. Short control messages go through two single-entry mailboxes. Each mailbox stores six bits, held in byte bits 7 to 2.

The host reads a level-based status byte, writes an interrupt-enable byte whose bit layout differs from the status layout, and can reset the window by writing to one address. The local processor has a simple port. On it, it pushes inbound data, pops outbound data, exchanges mailbox contents and arms the host interrupt. A mode input sets the usable FIFO depth. In word mode every entry of a FIFO is usable. In byte mode only half of them are.

Top module: `hbx_host_window`

## Requirements
- R1: After reset the status byte reads 0x21, the interrupt request is low, an empty data read returns 0, and the mailbox address reads 0.
- R2: A host write to address 0 pushes one outbound entry. With `host_word` set, the entry is the full 16-bit value, whose upper byte is the address-1 byte. With `host_word` clear, the entry is the low byte with the upper byte zero. The local side pops the entries in order. A pop of an empty FIFO is ignored, and `loc_out_rdata` is 0 while the FIFO is empty.
- R3: A host read of address 0 pops the inbound FIFO. A word read returns the whole entry. A byte read returns only the low byte, with the upper 8 bits zero.
- R4: Usable FIFO capacity is DEPTH entries when `wide_mode` is 1 and DEPTH/2 entries when it is 0. A push into a full FIFO is discarded.
- R5: Status bit 4 is set while the outbound count is at least half the capacity. Status bit 3 is the same flag for the inbound FIFO.
- R6: The status byte at address 2 is built as follows. Bit 7 is outbound mailbox pending. Bit 6 is outbound full. Bit 5 is inbound empty. Bit 4 is outbound half. Bit 3 is inbound half. Bit 2 is inbound mailbox full. Bit 1 is inbound full. Bit 0 is outbound empty. Each bit is a level that follows its condition.
- R7: Each mailbox keeps only byte bits 7..2, and bits 1..0 always read back as 0.
- R8: A host write to address 3 loads the outbound mailbox and sets status bit 7. A local read (`loc_mb_rd`) clears that bit. With mask bit 7 set, an address-3 read returns the outbound mailbox and does not clear the pending bit.
- R9: A local mailbox write sets status bit 2. A host read of address 3 with mask bit 7 clear returns the inbound mailbox and clears the bit. A read with mask bit 7 set leaves the bit alone.
- R10: Writes to address 2 set the interrupt enables, and only bits 7, 6, 5, 3, 2 and 0 are kept. Mask bit 6 enables inbound mailbox full (status 2). Bit 5 enables inbound full (status 1). Bit 3 enables inbound empty (status 5). Bit 2 enables outbound full (status 6). Bit 0 enables outbound empty (status 0). `host_irq` is high exactly when the global enable is set and at least one enabled condition holds.
- R11: The global interrupt enable is clear after reset and sets on a `loc_irq_en` pulse.
- R12: Any write to address 7 empties both FIFOs and clears the mailboxes, their flags, the mask and the global enable. It also pulses `brd_rst` for one cycle. Reads of addresses 1 and 4 to 7 return 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: word mode with full depth, 0: byte mode with half depth |
| host_addr | input | 3 | Host window address |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe |
| host_word | input | 1 | Access is word-wide |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid during the read cycle |
| host_irq | output | 1 | Host interrupt request |
| brd_rst | output | 1 | One-cycle pulse after a write to address 7 |
| loc_in_push | input | 1 | Local push into the inbound FIFO |
| loc_in_wdata | input | 16 | Inbound data |
| loc_in_full | output | 1 | Inbound FIFO at capacity |
| loc_out_pop | input | 1 | Local pop of the outbound FIFO |
| loc_out_rdata | output | 16 | Head of the outbound FIFO |
| loc_out_empty | output | 1 | Outbound FIFO empty |
| loc_mb_wr | input | 1 | Local write of the inbound mailbox |
| loc_mb_wdata | input | 6 | Inbound mailbox value (host byte bits 7..2) |
| loc_mb_rd | input | 1 | Local read of the outbound mailbox, consumes it |
| loc_mb_rdata | output | 6 | Outbound mailbox value |
| loc_mb_pend | output | 1 | Outbound mailbox not yet consumed |
| loc_irq_en | input | 1 | Pulse that sets the global host interrupt enable |

## Verification
The assertions assume that the host issues at most one access per cycle and never raises read and write together. They also assume that `wide_mode` changes only while both FIFOs are empty, so that no count exceeds the new capacity. The stimulus drives every host access and local action through one bench task, which raises a single host strobe per cycle. The bench changes the mode only after it has drained both FIFOs. Every clock, a queue-based model predicts the local outputs, the interrupt request and each host read.

// File: rtl/hbx_pkg.sv
// Package: addresses, status bit positions and mask bit positions shared
// by the host window logic. Status and mask layouts differ on purpose.
package hbx_pkg;
    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_MBOX = 3'd3;
    localparam logic [2:0] A_RST  = 3'd7;

    localparam int SB_OMB    = 7;
    localparam int SB_OFULL  = 6;
    localparam int SB_IEMPTY = 5;
    localparam int SB_OHALF  = 4;
    localparam int SB_IHALF  = 3;
    localparam int SB_IMB    = 2;
    localparam int SB_IFULL  = 1;
    localparam int SB_OEMPTY = 0;

    localparam int MK_RSEL   = 7;
    localparam int MK_IMB    = 6;
    localparam int MK_IFULL  = 5;
    localparam int MK_IEMPTY = 3;
    localparam int MK_OFULL  = 2;
    localparam int MK_OEMPTY = 0;

    localparam logic [7:0] MASK_KEEP = 8'hED;
    localparam logic [7:0] STAT_IDLE = 8'h21;
endpackage

// File: rtl/hbx_fifo.sv
// Module: hbx_fifo
// Circular FIFO with a run-time capacity limit (cap <= DEPTH). A push is
// accepted only below cap, and a pop only when not empty. Assumes DEPTH is a
// power of two, at least 2.
module hbx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          half
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign push_ok = push && (count < cap);
    assign pop_ok  = pop && (count != '0);
    assign empty   = (count == '0);
    assign full    = (count >= cap);
    assign half    = (count >= (cap >> 1));
    assign rdata   = mem[rptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

    // Pointer and occupancy update, cleared by reset or soft clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/hbx_mailbox.sv
// Module: hbx_mailbox
// Single six-bit message holder with a full flag. A write loads the value and
// sets the flag. Consume clears the flag but keeps the value. If both occur
// in one cycle, the write wins.
module hbx_mailbox #(
    parameter int MW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [MW-1:0] wdata,
    input  logic          consume,
    output logic [MW-1:0] data,
    output logic          flag
);
    // Value and flag register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            data <= '0;
            flag <= 1'b0;
        end else if (wr) begin
            data <= wdata;
            flag <= 1'b1;
        end else if (consume) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/hbx_stat_irq.sv
// Module: hbx_stat_irq
// Forms the status byte from the FIFO and mailbox conditions. It then maps
// the five enable bits onto their status bits, whose positions differ, and
// gates the interrupt request with the global enable. Purely combinational.
module hbx_stat_irq
    import hbx_pkg::*;
(
    input  logic       ob_pend,
    input  logic       ob_full,
    input  logic       ib_empty,
    input  logic       ob_half,
    input  logic       ib_half,
    input  logic       ib_mbf,
    input  logic       ib_full,
    input  logic       ob_empty,
    input  logic [4:0] en,
    input  logic       gen,
    output logic [7:0] status,
    output logic       irq
);
    logic [4:0] cond;

    // Status byte assembly.
    always_comb begin
        status            = '0;
        status[SB_OMB]    = ob_pend;
        status[SB_OFULL]  = ob_full;
        status[SB_IEMPTY] = ib_empty;
        status[SB_OHALF]  = ob_half;
        status[SB_IHALF]  = ib_half;
        status[SB_IMB]    = ib_mbf;
        status[SB_IFULL]  = ib_full;
        status[SB_OEMPTY] = ob_empty;
    end

    // Enable order: in mailbox, in full, in empty, out full, out empty.
    assign cond = {status[SB_IMB], status[SB_IFULL], status[SB_IEMPTY],
                   status[SB_OFULL], status[SB_OEMPTY]};
    assign irq  = gen && |(cond & en);
endmodule

// File: rtl/hbx_host_window.sv
// Module: hbx_host_window
// Board-side host window: address decode, the two data FIFOs, two mailboxes,
// the enable register, the global enable, the soft reset and the read mux.
// Assumes one host access per cycle and mode changes only while the FIFOs are
// empty. Host read data is combinational during the read cycle.
module hbx_host_window
    import hbx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wide_mode,
    input  logic [2:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_word,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_irq,
    output logic        brd_rst,
    input  logic        loc_in_push,
    input  logic [15:0] loc_in_wdata,
    output logic        loc_in_full,
    input  logic        loc_out_pop,
    output logic [15:0] loc_out_rdata,
    output logic        loc_out_empty,
    input  logic        loc_mb_wr,
    input  logic [5:0]  loc_mb_wdata,
    input  logic        loc_mb_rd,
    output logic [5:0]  loc_mb_rdata,
    output logic        loc_mb_pend,
    input  logic        loc_irq_en
);
    logic [CW-1:0] cap, ob_count, ib_count;
    logic          wr_data, rd_data, wr_stat, wr_mb, rd_mb, wr_rst;
    logic [15:0]   ob_wdata, ob_rdata, ib_rdata;
    logic          ob_empty, ob_full, ob_half, ib_empty, ib_full, ib_half;
    logic [7:0]    mask;
    logic          irq_gen, brd_rst_q;
    logic [5:0]    ob_mb, ib_mb;
    logic          ob_pend, ib_mbf;
    logic [7:0]    status;

    assign cap     = wide_mode ? CW'(DEPTH) : CW'(DEPTH / 2);
    assign wr_data = host_wr && (host_addr == A_DATA);
    assign rd_data = host_rd && (host_addr == A_DATA);
    assign wr_stat = host_wr && (host_addr == A_STAT);
    assign wr_mb   = host_wr && (host_addr == A_MBOX);
    assign rd_mb   = host_rd && (host_addr == A_MBOX);
    assign wr_rst  = host_wr && (host_addr == A_RST);
    assign ob_wdata = host_word ? host_wdata : {8'h00, host_wdata[7:0]};

    hbx_fifo #(.W(16), .DEPTH(DEPTH)) u_ob_fifo (
        .clk(clk), .rst_n(rst_n), .clr(wr_rst), .cap(cap),
        .push(wr_data), .wdata(ob_wdata), .pop(loc_out_pop),
        .rdata(ob_rdata), .count(ob_count), .empty(ob_empty),
        .full(ob_full), .half(ob_half)
    );

    hbx_fifo #(.W(16), .DEPTH(DEPTH)) u_ib_fifo (
        .clk(clk), .rst_n(rst_n), .clr(wr_rst), .cap(cap),
        .push(loc_in_push), .wdata(loc_in_wdata), .pop(rd_data),
        .rdata(ib_rdata), .count(ib_count), .empty(ib_empty),
        .full(ib_full), .half(ib_half)
    );

    hbx_mailbox #(.MW(6)) u_ob_mb (
        .clk(clk), .rst_n(rst_n), .clr(wr_rst), .wr(wr_mb),
        .wdata(host_wdata[7:2]), .consume(loc_mb_rd),
        .data(ob_mb), .flag(ob_pend)
    );

    hbx_mailbox #(.MW(6)) u_ib_mb (
        .clk(clk), .rst_n(rst_n), .clr(wr_rst), .wr(loc_mb_wr),
        .wdata(loc_mb_wdata), .consume(rd_mb && !mask[MK_RSEL]),
        .data(ib_mb), .flag(ib_mbf)
    );

    hbx_stat_irq u_stat (
        .ob_pend(ob_pend), .ob_full(ob_full), .ib_empty(ib_empty),
        .ob_half(ob_half), .ib_half(ib_half), .ib_mbf(ib_mbf),
        .ib_full(ib_full), .ob_empty(ob_empty),
        .en({mask[MK_IMB], mask[MK_IFULL], mask[MK_IEMPTY],
             mask[MK_OFULL], mask[MK_OEMPTY]}),
        .gen(irq_gen), .status(status), .irq(host_irq)
    );

    // Enable/flag register: reserved bits are dropped on write.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_rst) mask <= '0;
        else if (wr_stat)     mask <= host_wdata[7:0] & MASK_KEEP;
    end

    // Global interrupt enable, armed by the local side only.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_rst) irq_gen <= 1'b0;
        else if (loc_irq_en)  irq_gen <= 1'b1;
    end

    // One-cycle board reset pulse after a write to the reset address.
    always_ff @(posedge clk) begin
        if (!rst_n) brd_rst_q <= 1'b0;
        else        brd_rst_q <= wr_rst;
    end

    // Host read mux, zero outside a read and for unused addresses.
    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            unique case (host_addr)
                A_DATA: if (!ib_empty)
                            host_rdata = host_word ? ib_rdata : {8'h00, ib_rdata[7:0]};
                A_STAT: host_rdata = {8'h00, status};
                A_MBOX: host_rdata = {8'h00, (mask[MK_RSEL] ? ob_mb : ib_mb), 2'b00};
                default: host_rdata = '0;
            endcase
        end
    end

    assign brd_rst       = brd_rst_q;
    assign loc_in_full   = ib_full;
    assign loc_out_empty = ob_empty;
    assign loc_out_rdata = ob_empty ? 16'h0000 : ob_rdata;
    assign loc_mb_rdata  = ob_mb;
    assign loc_mb_pend   = ob_pend;
endmodule

// File: rtl/hbx_host_window_chk.sv
// Module: hbx_host_window_chk
// Property checker bound into hbx_host_window. It observes decoded host
// strobes, the status byte, the FIFO counts and the global enable.
module hbx_host_window_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    host_addr,
    input logic          host_wr,
    input logic          host_irq,
    input logic          brd_rst,
    input logic          loc_mb_wr,
    input logic [7:0]    status,
    input logic          irq_gen,
    input logic [CW-1:0] ob_count,
    input logic [CW-1:0] ib_count
);
    // R1: the first cycle out of reset shows the idle status and no request.
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (status == 8'h21) && !host_irq);

    // R4: no FIFO count ever exceeds its storage.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_count <= CW'(DEPTH)) && (ib_count <= CW'(DEPTH)));

    // R6: full and empty of one FIFO never show together.
    a_r6_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[6] && status[0]) && !(status[5] && status[1]));

    // R8: a host mailbox write leaves the pending bit set.
    a_r8_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd3) |=> status[7]);

    // R9: a local mailbox write sets inbound-full unless a soft reset coincides.
    a_r9_inmb_set: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_mb_wr && !(host_wr && host_addr == 3'd7)) |=> status[2]);

    // R11: no request while the global enable is clear.
    a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_gen |-> !host_irq);

    // R12: a reset-address write returns the window to idle and pulses brd_rst.
    a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd7) |=> (status == 8'h21) && !irq_gen && brd_rst);
endmodule

bind hbx_host_window hbx_host_window_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_irq(host_irq), .brd_rst(brd_rst), .loc_mb_wr(loc_mb_wr),
    .status(status), .irq_gen(irq_gen), .ob_count(ob_count), .ib_count(ib_count)
);

// File: tb/test_hbx_host_window.sv
// Bench: queue-based reference model of the window, compared every clock.
module test_hbx_host_window;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n, wide_mode;
    logic [2:0]  host_addr;
    logic        host_wr, host_rd, host_word;
    logic [15:0] host_wdata, host_rdata;
    logic        host_irq, brd_rst;
    logic        loc_in_push, loc_in_full, loc_out_pop, loc_out_empty;
    logic [15:0] loc_in_wdata, loc_out_rdata;
    logic        loc_mb_wr, loc_mb_rd, loc_mb_pend, loc_irq_en;
    logic [5:0]  loc_mb_wdata, loc_mb_rdata;

    always #2 clk = ~clk;

    hbx_host_window #(.DEPTH(DEPTH)) i_hbx_host_window (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int obq[$], ibq[$];
    logic [5:0] m_obmb, m_ibmb;
    bit m_obp, m_ibf, m_gen, m_brd;
    logic [7:0] m_mask;

    function automatic int cap();
        return wide_mode ? DEPTH : DEPTH / 2;
    endfunction

    function automatic logic [7:0] m_status();
        return {m_obp, obq.size() >= cap(), ibq.size() == 0, obq.size() >= cap() / 2,
                ibq.size() >= cap() / 2, m_ibf, ibq.size() >= cap(), obq.size() == 0};
    endfunction

    function automatic bit m_irq();
        logic [7:0] s;
        s = m_status();
        return m_gen && ((m_mask[6] && s[2]) || (m_mask[5] && s[1]) || (m_mask[3] && s[5])
                      || (m_mask[2] && s[6]) || (m_mask[0] && s[0]));
    endfunction

    function automatic logic [15:0] m_read(logic [2:0] a, bit wd);
        case (a)
            3'd0: return (ibq.size() == 0) ? 16'h0 : (wd ? 16'(ibq[0]) : 16'(ibq[0] & 255));
            3'd2: return {8'h0, m_status()};
            3'd3: return {8'h0, (m_mask[7] ? m_obmb : m_ibmb), 2'b00};
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic m_clear();
        obq.delete(); ibq.delete();
        m_obmb = 0; m_ibmb = 0; m_obp = 0; m_ibf = 0; m_gen = 0; m_mask = 0;
    endtask

    // One clock of stimulus, model update and comparison.
    task automatic cyc(logic [2:0] a, bit w, bit r, bit wd, logic [15:0] d,
                       bit lpush, logic [15:0] ldat, bit lpop, bit lmbw,
                       logic [5:0] lmbd, bit lmbr, bit lien, string tag);
        logic [15:0] exp;
        bit ob_pop, ob_push, ib_pop, ib_push;
        @(negedge clk);
        host_addr = a; host_wr = w; host_rd = r; host_word = wd; host_wdata = d;
        loc_in_push = lpush; loc_in_wdata = ldat; loc_out_pop = lpop;
        loc_mb_wr = lmbw; loc_mb_wdata = lmbd; loc_mb_rd = lmbr; loc_irq_en = lien;
        #1;
        if (r) begin
            exp = m_read(a, wd);
            check(host_rdata === exp, tag, host_rdata, exp);
        end
        @(posedge clk);
        if (w && a == 3'd7) begin
            m_clear();
            m_brd = 1;
        end else begin
            m_brd   = 0;
            ob_pop  = lpop && obq.size() > 0;
            ob_push = w && a == 3'd0 && obq.size() < cap();
            ib_pop  = r && a == 3'd0 && ibq.size() > 0;
            ib_push = lpush && ibq.size() < cap();
            if (ob_pop)  void'(obq.pop_front());
            if (ob_push) obq.push_back(wd ? int'(d) : int'(d & 16'h00FF));
            if (ib_pop)  void'(ibq.pop_front());
            if (ib_push) ibq.push_back(int'(ldat));
            if (lmbw) begin
                m_ibmb = lmbd; m_ibf = 1;
            end else if (r && a == 3'd3 && !m_mask[7]) begin
                m_ibf = 0;
            end
            if (w && a == 3'd3) begin
                m_obmb = d[7:2]; m_obp = 1;
            end else if (lmbr) begin
                m_obp = 0;
            end
            if (w && a == 3'd2) m_mask = d[7:0] & 8'hED;
            if (lien) m_gen = 1;
        end
        #1;
        exp = (obq.size() == 0) ? 16'h0 : 16'(obq[0]);
        check(loc_out_rdata === exp, "R2", loc_out_rdata, exp);
        check(loc_out_empty === (obq.size() == 0), "R2", loc_out_empty, obq.size() == 0);
        check(loc_in_full === (ibq.size() >= cap()), "R4", loc_in_full, ibq.size() >= cap());
        check(loc_mb_pend === m_obp, "R8", loc_mb_pend, m_obp);
        check(loc_mb_rdata === m_obmb, "R7", loc_mb_rdata, m_obmb);
        check(host_irq === m_irq(), "R10", host_irq, m_irq());
        check(brd_rst === m_brd, "R12", brd_rst, m_brd);
        host_wr = 0; host_rd = 0; loc_in_push = 0; loc_out_pop = 0;
        loc_mb_wr = 0; loc_mb_rd = 0; loc_irq_en = 0;
    endtask

    task automatic hwr(logic [2:0] a, logic [15:0] d, bit wd);
        cyc(a, 1, 0, wd, d, 0, 0, 0, 0, 0, 0, 0, "R2");
    endtask
    task automatic hrd(logic [2:0] a, bit wd, string tag);
        cyc(a, 0, 1, wd, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic lpush(logic [15:0] d);
        cyc(0, 0, 0, 0, 0, 1, d, 0, 0, 0, 0, 0, "R3");
    endtask
    task automatic lpop();
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R2");
    endtask
    task automatic lmbw(logic [5:0] d);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, d, 0, 0, "R9");
    endtask
    task automatic lmbr();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    endtask
    task automatic lien();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R11");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wide_mode = 1; host_addr = 0; host_wr = 0; host_rd = 0;
        host_word = 0; host_wdata = 0; loc_in_push = 0; loc_in_wdata = 0;
        loc_out_pop = 0; loc_mb_wr = 0; loc_mb_wdata = 0; loc_mb_rd = 0; loc_irq_en = 0;
        m_clear(); m_brd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: idle state after reset.
        hrd(2, 0, "R1"); hrd(0, 1, "R1"); hrd(3, 0, "R1");

        // R2: word and byte host writes, drained in order, extra pop ignored.
        hwr(0, 16'h1234, 1); hwr(0, 16'h99EE, 0);
        lpop(); lpop(); lpop();

        // R3: word read, then byte read keeps only the low byte.
        lpush(16'hBEEF); lpush(16'h0102);
        hrd(0, 1, "R3"); hrd(0, 0, "R3"); hrd(0, 1, "R3");

        // R4 / R5 / R6: fill outbound in word mode past capacity.
        for (int i = 0; i < 4; i++) hwr(0, 16'(16'hA000 + i), 1);
        hrd(2, 0, "R6");
        for (int i = 4; i < 8; i++) hwr(0, 16'(16'hA000 + i), 1);
        hrd(2, 0, "R5");
        for (int i = 8; i < 17; i++) hwr(0, 16'(16'hA000 + i), 1);
        hrd(2, 0, "R4");
        for (int i = 0; i < 17; i++) lpop();
        // Inbound side in word mode.
        for (int i = 0; i < 17; i++) lpush(16'(16'h5000 + i));
        hrd(2, 0, "R4");
        for (int i = 0; i < 17; i++) hrd(0, 1, "R3");

        // R4 / R5: byte mode halves capacity.
        @(negedge clk) wide_mode = 0;
        for (int i = 0; i < 4; i++) hwr(0, 16'(16'h0040 + i), 0);
        hrd(2, 0, "R5");
        for (int i = 4; i < 9; i++) hwr(0, 16'(16'h0040 + i), 0);
        hrd(2, 0, "R4");
        for (int i = 0; i < 9; i++) lpush(16'(16'h0070 + i));
        hrd(2, 0, "R4");
        for (int i = 0; i < 9; i++) begin lpop(); hrd(0, 0, "R3"); end
        @(negedge clk) wide_mode = 1;

        // R7 / R8: outbound mailbox, pending bit, non-destructive readback.
        hwr(3, 16'h00FF, 0);
        hrd(2, 0, "R8");
        hwr(2, 16'h0080, 0);
        hrd(3, 0, "R7"); hrd(2, 0, "R8");
        lmbr();
        hrd(2, 0, "R8");

        // R9: inbound mailbox kept while selector set, consumed when clear.
        lmbw(6'h15);
        hrd(3, 0, "R9"); hrd(2, 0, "R9");
        hwr(2, 16'h0000, 0);
        hrd(3, 0, "R7"); hrd(2, 0, "R9");

        // R10 / R11: enables without the global enable, then armed.
        hwr(2, 16'h00FF, 0);
        hrd(2, 0, "R11");
        lien();
        hrd(2, 0, "R10");
        hwr(2, 16'h0000, 0); hwr(2, 16'h0010, 0); hwr(2, 16'h0001, 0);
        hwr(2, 16'h0004, 0);
        hwr(0, 16'h1111, 1);
        for (int i = 0; i < 16; i++) hwr(0, 16'(i), 1);
        for (int i = 0; i < 16; i++) lpop();
        hwr(2, 16'h0040, 0);
        lmbw(6'h2A);
        hrd(3, 0, "R10");
        hwr(2, 16'h0020, 0);
        for (int i = 0; i < 16; i++) lpush(16'(i));
        for (int i = 0; i < 16; i++) hrd(0, 1, "R10");

        // R12: soft reset clears everything; unused reads return zero.
        hwr(0, 16'h7777, 1); lpush(16'h8888); lmbw(6'h3F); hwr(3, 16'h00C0, 0);
        hwr(2, 16'h00C5, 0); lien();
        hwr(7, 16'h0000, 0);
        hrd(2, 0, "R12"); hrd(3, 0, "R12"); hrd(0, 1, "R12");
        hrd(7, 0, "R12"); hrd(5, 0, "R12"); hrd(1, 0, "R12");
        hwr(2, 16'h0001, 0);
        hrd(2, 0, "R12");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule